// File: doc/BRIEF.md
# Sticky Overflow Status Word with Set and Clear Aliases

This block holds a 64-bit sticky status word. The word gathers overflow and freeze indications from a bank of performance counters and from a few related sources. Hardware event inputs set individual bits, and a bit stays set until software clears it. Software reaches the word through a simple single-address register bus that exposes three views:

- a read-only status view;
- a clear alias, where each 1 written clears the matching bit;
- a set alias, where each 1 written sets the matching bit.

The bit positions are fixed so that neighbouring logic can decode them:

| Bits | Meaning |
|------|---------|
| 0..7 | general-counter overflows |
| 32..34 | fixed-counter overflows |
| 55 | trace-buffer interrupt |
| 58 | branch-record freeze |
| 59 | counter freeze |
| 60 | secure-mode flag |
| 61 | uncore overflow |
| 62 | store-buffer overflow |
| 63 | condition changed |

The parameter `NUM_GP` gives how many general counters are implemented; its default is 6. General-counter flags at or above that count do not exist. The full word is also driven out continuously, for downstream interrupt or freeze logic.

Top module: `ovf_status_reg`

## Requirements
- R1: After reset every status bit is 0.
- R2: A write to the clear alias (address 2) clears each status bit whose data bit is 1 and leaves bits written 0 unchanged.
- R3: A write to the set alias (address 3) sets each implemented status bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: Bit 63 (condition changed) is never set by the set alias. It is set by its hardware event and cleared through the clear alias.
- R5: General-counter flag i (bit i, 0..7) exists only when i < NUM_GP. Otherwise it reads 0 and ignores set-alias writes and events.
- R6: Bits 8..31, 35..54 and 56..57 always read 0, whatever is written to either alias or asserted on the event inputs.
- R7: When an event and a clear-alias write target the same bit in the same cycle, the bit ends up set.
- R8: A one-cycle event pulse on an implemented bit sets that bit on the next clock edge, and the bit stays set until it is cleared.
- R9: Writes to the status view (address 0) change nothing.
- R10: busRdData shows the current status word when busAddr is 0, 2 or 3, and 0 for any other address. It is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 4 | Register bus address |
| busWrData | input | 64 | Register bus write data |
| busRdData | output | 64 | Register bus read data |
| hwEvent | input | 64 | Per-bit event pulses from the sources |
| statusOut | output | 64 | Current status word |

## Verification
Every write and every event takes effect on the first rising edge that samples it, so the new status is due one cycle after the stimulus. Read data follows the address with no delay.

Each bench task therefore drives its stimulus just after a falling edge and holds it through one rising edge. It then releases the inputs one nanosecond after that edge and samples both outputs at that point. Read-mux checks change only the address and sample after a short settle, with no clock edge in between.

// File: rtl/ovf_status_pkg.sv
package ovf_status_pkg;

  localparam int STATUS_W  = 64;
  localparam int GP_MAX    = 8;
  localparam int FIX_LO    = 32;
  localparam int FIX_CNT   = 3;
  localparam int TRACE_BIT = 55;
  localparam int FRZ_LO    = 58;
  localparam int COND_BIT  = 63;

  typedef struct packed {
    logic setWr;
    logic clrWr;
  } wrStrobe_t;

  // Bits that physically exist for a given general-counter count
  function automatic logic [STATUS_W-1:0] implMaskFn(int numGp);
    logic [STATUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < GP_MAX; i++) begin
      if (i < numGp) m[i] = 1'b1;
    end
    for (int i = 0; i < FIX_CNT; i++) m[FIX_LO + i] = 1'b1;
    m[TRACE_BIT] = 1'b1;
    for (int i = FRZ_LO; i <= COND_BIT; i++) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ovf_status_ctrl.sv
module ovf_status_ctrl
  import ovf_status_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int CLEAR_ADDR  = 2,
  parameter int SET_ADDR    = 3
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         strb,
  output logic              rdHit
);

  logic hitStatus, hitClear, hitSet;

  always_comb begin
    hitStatus  = (busAddr == ADDR_W'(STATUS_ADDR));
    hitClear   = (busAddr == ADDR_W'(CLEAR_ADDR));
    hitSet     = (busAddr == ADDR_W'(SET_ADDR));
    // A write to the status view decodes to no strobe
    strb.clrWr = busWrEn && hitClear;
    strb.setWr = busWrEn && hitSet;
    rdHit      = hitStatus || hitClear || hitSet;
  end

endmodule

// File: rtl/ovf_status_dp.sv
module ovf_status_dp
  import ovf_status_pkg::*;
#(
  parameter int NUM_GP = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strb,
  input  logic                rdHit,
  input  logic [STATUS_W-1:0] wrData,
  input  logic [STATUS_W-1:0] hwEvent,
  output logic [STATUS_W-1:0] status,
  output logic [STATUS_W-1:0] rdData
);

  localparam logic [STATUS_W-1:0] IMPL_MASK = implMaskFn(NUM_GP);
  localparam logic [STATUS_W-1:0] SET_MASK  = IMPL_MASK & ~(STATUS_W'(1) << COND_BIT);

  logic [STATUS_W-1:0] clrVec, setVec, evVec, statusNext;

  always_comb begin
    clrVec     = strb.clrWr ? wrData : '0;
    setVec     = strb.setWr ? (wrData & SET_MASK) : '0;
    evVec      = hwEvent & IMPL_MASK;
    // Sets (software or event) are applied after the clear, so they win
    statusNext = ((status & ~clrVec) | setVec | evVec) & IMPL_MASK;
    rdData     = rdHit ? status : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= statusNext;
  end

  // R2: cleared bits without a competing event are 0 afterwards
  assert_clear_alias_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((status & $past(wrData & ~hwEvent)) == '0));

  // R3: set-alias bits are present afterwards
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((status & $past(wrData & SET_MASK)) == $past(wrData & SET_MASK)));

  // R4: condition-changed bit rises only on its event
  assert_cond_only_hw_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[COND_BIT]) |-> $past(hwEvent[COND_BIT]));

  // R7 / R8: event bits are always captured
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(hwEvent & IMPL_MASK)) == $past(hwEvent & IMPL_MASK)));

  // R8: bits only fall after a clear-alias write
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(status) & ~status) != '0) |-> $past(strb.clrWr));

endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
  import ovf_status_pkg::*;
#(
  parameter int NUM_GP      = 6,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int CLEAR_ADDR  = 2,
  parameter int SET_ADDR    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [STATUS_W-1:0] busWrData,
  output logic [STATUS_W-1:0] busRdData,
  input  logic [STATUS_W-1:0] hwEvent,
  output logic [STATUS_W-1:0] statusOut
);

  wrStrobe_t strb;
  logic      rdHit;

  ovf_status_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .CLEAR_ADDR(CLEAR_ADDR), .SET_ADDR(SET_ADDR)
  ) i_ctrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .strb(strb), .rdHit(rdHit)
  );

  ovf_status_dp #(.NUM_GP(NUM_GP)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdHit(rdHit),
    .wrData(busWrData), .hwEvent(hwEvent),
    .status(statusOut), .rdData(busRdData)
  );

endmodule

// File: tb/test_ovf_status_reg.sv
module test_ovf_status_reg;

  localparam logic [63:0] IMPL = 64'hFC80_0007_0000_003F; // NUM_GP = 6
  localparam logic [63:0] SETM = 64'h7C80_0007_0000_003F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = 4'd0;
  logic [63:0] busWrData = '0;
  logic [63:0] hwEvent = '0;
  logic [63:0] busRdData, statusOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ovf_status_reg i_ovf_status_reg (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .hwEvent(hwEvent), .statusOut(statusOut)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // One bus cycle; outputs sampled 1 ns after the capturing edge
  task automatic cycle(logic we, logic [3:0] a, logic [63:0] d, logic [63:0] ev);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; hwEvent = ev;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; busWrData = '0; hwEvent = '0; busAddr = 4'd0;
  endtask

  task automatic testReset();
    check("R1 reset status", statusOut, 64'h0);
    check("R10 read status view", busRdData, 64'h0);
  endtask

  task automatic testEvents();
    cycle(1'b0, 4'd0, '0, '1);
    check("R8 R5 R6 all events", statusOut, IMPL);
    cycle(1'b0, 4'd0, '0, '0);
    check("R8 sticky", statusOut, IMPL);
  endtask

  task automatic testClear();
    cycle(1'b1, 4'd2, 64'h0, '0);
    check("R2 zero write no effect", statusOut, IMPL);
    cycle(1'b1, 4'd2, 64'h5, '0);
    check("R2 clear bits 0 and 2", statusOut, IMPL & ~64'h5);
    cycle(1'b1, 4'd2, '1, '0);
    check("R2 R4 clear all", statusOut, 64'h0);
  endtask

  task automatic testSet();
    cycle(1'b1, 4'd3, 64'h20, '0);
    check("R5 set implemented bit 5", statusOut, 64'h20);
    cycle(1'b1, 4'd3, 64'h40, '0);
    check("R5 set absent bit 6 ignored", statusOut, 64'h20);
    cycle(1'b1, 4'd3, '1, '0);
    check("R3 R4 R6 set all", statusOut, SETM);
    cycle(1'b1, 4'd3, 64'h0, '0);
    check("R3 zero write no effect", statusOut, SETM);
  endtask

  task automatic testStatusView();
    cycle(1'b1, 4'd2, '1, '0);
    cycle(1'b1, 4'd0, '1, '0);
    check("R9 status view write ignored", statusOut, 64'h0);
    cycle(1'b1, 4'd3, 64'h3, '0);
    cycle(1'b1, 4'd0, 64'h0, '0);
    check("R9 status view zero write ignored", statusOut, 64'h3);
  endtask

  task automatic testRace();
    // status = 0x3; clear bits 0,1 while event hits bit 1
    cycle(1'b1, 4'd2, 64'h3, 64'h2);
    check("R7 event beats clear", statusOut, 64'h2);
  endtask

  task automatic testCondBit();
    cycle(1'b0, 4'd0, '0, 64'h8000_0000_0000_0000);
    check("R4 event sets bit 63", statusOut, 64'h8000_0000_0000_0002);
    cycle(1'b1, 4'd2, 64'h8000_0000_0000_0000, '0);
    check("R4 clear bit 63", statusOut, 64'h2);
  endtask

  task automatic testReadMux();
    @(negedge clk);
    busAddr = 4'd1; #1;
    check("R10 unmapped reads 0", busRdData, 64'h0);
    busAddr = 4'd2; #1;
    check("R10 clear alias reads status", busRdData, 64'h2);
    busAddr = 4'd3; #1;
    check("R10 set alias reads status", busRdData, 64'h2);
    busAddr = 4'd0; #1;
    check("R10 status view reads status", busRdData, 64'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testEvents();
    testClear();
    testSet();
    testStatusView();
    testRace();
    testCondBit();
    testReadMux();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule